// File: doc/BRIEF.md
# Volume and Tone Register Decoder

This block is the digital back end of a two-channel volume and tone controller. A serial bus front end delivers each transfer as a mode mask and a data byte, together with a one-cycle write strobe. The mask selects which control latches take the byte: channel-1 volume, channel-2 volume, bass, treble, and the mute flag. Because the mask holds one bit per mode, a single byte can set both channel volumes together, or set bass and treble together.

Volume bytes are decoded into an attenuation in whole dB plus a flag for full silence. The byte holds a coarse field with 2 dB steps down to 42 dB and 4 dB steps beyond that. It also holds a fine field that adds up to 3 dB. Tone bytes hold treble in the upper nibble and bass in the lower nibble. Each nibble decodes to a signed gain in 2 dB steps. All outputs are held registers intended to drive the select lines of analog switch ladders. A tone nibble outside the legal set is refused, and a one-cycle error pulse is raised.

Top module: `vol_tone_decoder`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first write, both channels show attenuation all-ones with `chN_silent`=1, both tone gains are 0, `mute_on`=0 and `bad_code`=0.
- R2: A write whose mask has bit2=0 and bit3=0 loads channel-1 volume when bit0=1 and channel-2 volume when bit1=1, both from the same data byte. The result is visible after the capturing clock edge.
- R3: A write whose mask has bit2 or bit3 set leaves both volume outputs unchanged, whatever bits 0 and 1 hold.
- R4: A write whose mask has bit0=0 and bit1=0 loads bass from data[3:0] when bit2=1 and treble from data[7:4] when bit3=1. A write with bit0 or bit1 set leaves both gains unchanged.
- R5: Every write sets `mute_on` to mask bit4, independent of mask bits 0 to 3.
- R6: Coarse volume c=data[6:2] gives 2*(31-c) dB for c from 31 down to 10 (0..42 dB), and 46+4*(9-c) dB for c from 9 down to 1 (46..78 dB).
- R7: Fine volume f=data[1:0] adds f dB when the coarse value is below 42 dB. At 42 dB or more, 2 and 3 are clamped to 0 and 1.
- R8: Coarse code 0 gives full silence: `chN_silent`=1 and attenuation all-ones. Any other code gives `chN_silent`=0 and attenuation at most 79.
- R9: A tone nibble {s,m2,m1,m0} with m=m2..m0 in 0..6 decodes to +2*m dB when s=0, and to -2*m dB when s=1 and m is non-zero. The result is in two's complement.
- R10: Tone nibbles 4'b0111, 4'b1000 and 4'b1111 are unused. When such a nibble is selected in a tone write, the latch it addresses keeps its value and `bad_code` is high for exactly the one cycle after the write.
- R11: With `wr_en` low, no output except `bad_code` changes, and `bad_code` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle write strobe |
| mode_mask | input | 5 | Mode mask: bit0 ch1 vol, bit1 ch2 vol, bit2 bass, bit3 treble, bit4 mute |
| wr_data | input | 8 | Data byte |
| ch1_att_db | output | ATT_W | Channel-1 attenuation in dB |
| ch1_silent | output | 1 | Channel-1 full silence |
| ch2_att_db | output | ATT_W | Channel-2 attenuation in dB |
| ch2_silent | output | 1 | Channel-2 full silence |
| bass_gain_db | output | GAIN_W | Signed bass gain in dB |
| treble_gain_db | output | GAIN_W | Signed treble gain in dB |
| mute_on | output | 1 | Mute latch |
| bad_code | output | 1 | Pulse on an unused tone nibble |

## Verification
The bench builds the block with the default ATT_W=7, GAIN_W=5 and FINE_KNEE_DB=42. These values hold the full 0..79 dB range with the all-ones silence value, and the full ±12 dB gain span. With these defaults every coarse step, the 42/46 dB knee and the fine clamp at both sides of the knee can be reached. Random masks cover the mixed volume-and-tone masks that must be refused. The directed cases aim at the knee codes, the silence code and each of the three unused tone nibbles.

// File: rtl/vol_tone_decoder.sv
module vol_tone_decoder #(
  parameter int ATT_W        = 7,
  parameter int GAIN_W       = 5,
  parameter int FINE_KNEE_DB = 42
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [4:0]               mode_mask,
  input  logic [7:0]               wr_data,
  output logic [ATT_W-1:0]         ch1_att_db,
  output logic                     ch1_silent,
  output logic [ATT_W-1:0]         ch2_att_db,
  output logic                     ch2_silent,
  output logic signed [GAIN_W-1:0] bass_gain_db,
  output logic signed [GAIN_W-1:0] treble_gain_db,
  output logic                     mute_on,
  output logic                     bad_code
);

  localparam logic [ATT_W-1:0] SILENT_ATT = '1;

  function automatic logic [ATT_W:0] vol_decode(input logic [6:0] code);
    int steps, base, fine;
    steps = 31 - int'(code[6:2]);
    fine  = int'(code[1:0]);
    if (steps == 31) return {1'b1, SILENT_ATT};
    base = (steps <= 21) ? 2 * steps : 46 + 4 * (steps - 22);
    if (base >= FINE_KNEE_DB && fine >= 2) fine = fine - 2;
    return {1'b0, ATT_W'(base + fine)};
  endfunction

  function automatic logic [GAIN_W:0] tone_decode(input logic [3:0] code);
    int mag;
    logic ok;
    mag = int'(code[2:0]);
    ok  = (mag <= 6) && !(code[3] && mag == 0);
    return {ok, GAIN_W'(code[3] ? -2 * mag : 2 * mag)};
  endfunction

  logic                     v_inf, b_ok, t_ok;
  logic [ATT_W-1:0]         v_att;
  logic signed [GAIN_W-1:0] b_gain, t_gain;

  assign {v_inf, v_att} = vol_decode(wr_data[6:0]);
  assign {b_ok, b_gain} = tone_decode(wr_data[3:0]);
  assign {t_ok, t_gain} = tone_decode(wr_data[7:4]);

  wire vol_wr  = wr_en && (mode_mask[0] || mode_mask[1]) && !mode_mask[2] && !mode_mask[3];
  wire tone_wr = wr_en && !mode_mask[0] && !mode_mask[1] && (mode_mask[2] || mode_mask[3]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ch1_att_db     <= SILENT_ATT;
      ch1_silent     <= 1'b1;
      ch2_att_db     <= SILENT_ATT;
      ch2_silent     <= 1'b1;
      bass_gain_db   <= '0;
      treble_gain_db <= '0;
      mute_on        <= 1'b0;
      bad_code       <= 1'b0;
    end else begin
      bad_code <= tone_wr && ((mode_mask[2] && !b_ok) || (mode_mask[3] && !t_ok));
      if (wr_en) mute_on <= mode_mask[4];
      if (vol_wr && mode_mask[0]) begin
        ch1_att_db <= v_att;
        ch1_silent <= v_inf;
      end
      if (vol_wr && mode_mask[1]) begin
        ch2_att_db <= v_att;
        ch2_silent <= v_inf;
      end
      if (tone_wr && mode_mask[2] && b_ok) bass_gain_db   <= b_gain;
      if (tone_wr && mode_mask[3] && t_ok) treble_gain_db <= t_gain;
    end
  end

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(ch1_att_db) && $stable(ch2_att_db) && $stable(ch1_silent)
                && $stable(ch2_silent) && $stable(bass_gain_db) && $stable(treble_gain_db)
                && $stable(mute_on) && !bad_code));

  assert_mute_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mute_on == $past(mode_mask[4])));

  assert_vol_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (mode_mask[2] || mode_mask[3])) |=> ($stable(ch1_att_db) && $stable(ch2_att_db)));

  assert_tone_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (mode_mask[0] || mode_mask[1])) |=> ($stable(bass_gain_db) && $stable(treble_gain_db) && !bad_code));

  assert_att_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ch1_silent |-> ch1_att_db <= ATT_W'(79)) and (!ch2_silent |-> ch2_att_db <= ATT_W'(79)));

  assert_gain_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bass_gain_db >= -12) && (bass_gain_db <= 12) && !bass_gain_db[0]
    && (treble_gain_db >= -12) && (treble_gain_db <= 12) && !treble_gain_db[0]);

  assert_err_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_code && !wr_en) |=> !bad_code);

endmodule

// File: tb/vol_tone_decoder_test.sv
module vol_tone_decoder_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [4:0] mode_mask = '0;
  logic [7:0] wr_data = '0;
  logic [6:0] ch1_att_db, ch2_att_db;
  logic ch1_silent, ch2_silent, mute_on, bad_code;
  logic signed [4:0] bass_gain_db, treble_gain_db;

  always #4 clk = ~clk;

  vol_tone_decoder uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .mode_mask(mode_mask), .wr_data(wr_data),
    .ch1_att_db(ch1_att_db), .ch1_silent(ch1_silent), .ch2_att_db(ch2_att_db),
    .ch2_silent(ch2_silent), .bass_gain_db(bass_gain_db), .treble_gain_db(treble_gain_db),
    .mute_on(mute_on), .bad_code(bad_code));

  int checks = 0, errors = 0;
  bit done = 0;
  int e_att1, e_att2, e_bass, e_treb;
  bit e_sil1, e_sil2, e_mute, e_err;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_att(input logic [6:0] code);
    int c, f, a;
    c = int'(code[6:2]);
    f = int'(code[1:0]);
    if (c == 0) return 127;
    if (c >= 10) a = 2 * (31 - c);
    else a = 78 - 4 * (c - 1);
    if (a < 42) return a + f;
    return a + (f % 2);
  endfunction

  function automatic bit tone_valid(input logic [3:0] n);
    return !(n == 4'b0111 || n == 4'b1000 || n == 4'b1111);
  endfunction

  function automatic int exp_gain(input logic [3:0] n);
    case (n)
      4'b0000: return 0;   4'b0001: return 2;   4'b0010: return 4;
      4'b0011: return 6;   4'b0100: return 8;   4'b0101: return 10;
      4'b0110: return 12;  4'b1001: return -2;  4'b1010: return -4;
      4'b1011: return -6;  4'b1100: return -8;  4'b1101: return -10;
      4'b1110: return -12; default: return 0;
    endcase
  endfunction

  task automatic compare(input string ctx);
    check(int'(ch1_att_db) == e_att1, {"R2/R6/R7 ch1 att ", ctx}, int'(ch1_att_db), e_att1);
    check(ch1_silent == e_sil1, {"R8 ch1 silent ", ctx}, int'(ch1_silent), int'(e_sil1));
    check(int'(ch2_att_db) == e_att2, {"R2/R3 ch2 att ", ctx}, int'(ch2_att_db), e_att2);
    check(ch2_silent == e_sil2, {"R8 ch2 silent ", ctx}, int'(ch2_silent), int'(e_sil2));
    check(int'(bass_gain_db) == e_bass, {"R4/R9 bass ", ctx}, int'(bass_gain_db), e_bass);
    check(int'(treble_gain_db) == e_treb, {"R4/R9 treble ", ctx}, int'(treble_gain_db), e_treb);
    check(mute_on == e_mute, {"R5 mute ", ctx}, int'(mute_on), int'(e_mute));
    check(bad_code == e_err, {"R10 bad_code ", ctx}, int'(bad_code), int'(e_err));
  endtask

  task automatic write(input logic [4:0] m, input logic [7:0] d, input string ctx);
    bit vw, tw;
    @(negedge clk);
    wr_en = 1'b1; mode_mask = m; wr_data = d;
    vw = (m[0] || m[1]) && !m[2] && !m[3];
    tw = !m[0] && !m[1] && (m[2] || m[3]);
    e_mute = m[4];
    e_err = tw && ((m[2] && !tone_valid(d[3:0])) || (m[3] && !tone_valid(d[7:4])));
    if (vw && m[0]) begin e_att1 = exp_att(d[6:0]); e_sil1 = (d[6:2] == 5'd0); end
    if (vw && m[1]) begin e_att2 = exp_att(d[6:0]); e_sil2 = (d[6:2] == 5'd0); end
    if (tw && m[2] && tone_valid(d[3:0])) e_bass = exp_gain(d[3:0]);
    if (tw && m[3] && tone_valid(d[7:4])) e_treb = exp_gain(d[7:4]);
    @(negedge clk);
    wr_en = 1'b0;
    compare(ctx);
  endtask

  task automatic idle(input string ctx);
    @(negedge clk);
    e_err = 1'b0;
    compare(ctx);
  endtask

  initial begin
    e_att1 = 127; e_att2 = 127; e_sil1 = 1; e_sil2 = 1;
    e_bass = 0; e_treb = 0; e_mute = 0; e_err = 0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    compare("R1 during reset");
    rst_n = 1'b1;
    idle("R1 after reset");

    write(5'b00001, 8'h7F, "R7 ch1 0dB coarse fine 3");
    write(5'b00011, {1'b0, 5'd10, 2'd3}, "R7 both at knee 42 fine 3 clamped");
    write(5'b00010, {1'b0, 5'd10, 2'd2}, "R7 ch2 knee fine 2 clamped");
    write(5'b00001, {1'b0, 5'd11, 2'd3}, "R7 ch1 40dB fine 3 kept");
    write(5'b00010, {1'b0, 5'd9, 2'd1}, "R6 ch2 46dB");
    write(5'b00001, {1'b0, 5'd1, 2'd3}, "R6 ch1 78dB fine clamp");
    write(5'b00010, {1'b1, 5'd0, 2'd2}, "R8 ch2 silence");
    write(5'b00101, 8'h7C, "R3 volume blocked by bass bit");
    write(5'b01011, 8'h7C, "R3 volume blocked by treble bit");
    write(5'b00100, 8'h06, "R9 bass +12");
    write(5'b01000, 8'hE0, "R9 treble -12");
    write(5'b01100, 8'h19, "R4 both tone");
    write(5'b01101, 8'h33, "R4 tone blocked by volume bit");
    write(5'b00100, 8'h07, "R10 bass unused 0111");
    idle("R10 R11 pulse ends");
    write(5'b01000, 8'h80, "R10 treble unused 1000");
    write(5'b01100, 8'hF2, "R10 treble unused 1111 bass taken");
    write(5'b00100, 8'h08, "R10 bass 1000 not selected treble");
    write(5'b10000, 8'h00, "R5 mute alone");
    write(5'b10011, 8'h7F, "R5 mute with volume");
    write(5'b00000, 8'hFF, "R5 empty mask clears mute");
    repeat (3) idle("R11 idle hold");

    for (int i = 0; i < 400; i++) begin
      logic [4:0] m;
      logic [7:0] d;
      m = 5'($urandom);
      d = 8'($urandom);
      if (i % 4 == 0) d[3:0] = 4'b0111;
      write(m, d, "R2 R4 R6 R7 random");
      if (i % 7 == 0) idle("R11 random idle");
    end

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    e_att1 = 127; e_att2 = 127; e_sil1 = 1; e_sil2 = 1;
    e_bass = 0; e_treb = 0; e_mute = 0; e_err = 0;
    compare("R1 re-reset");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule